// File: doc/BRIEF.md
# Edge-to-Clock Jitter Peak Tracker

This block measures how far received data transitions wander in time against a recovered bit clock. On each qualifying data transition it starts a counter that advances on every pulse of a sample tick running at one hundred times the bit rate. The counter stops at the next bit-clock edge. Each completed count is therefore the edge-to-clock interval in percent of one bit period.

Across a test the block keeps two values: the smallest interval seen, and the spread between the largest and the smallest. The spread is the peak-to-peak jitter, already in percent. The largest interval is never stored. It is recognised by comparing an interval against the smallest value plus the spread. In the total-peak mode falling transitions qualify as well as rising ones, so duty-cycle bias adds to the result.

A start pulse clears the test. An external-clock select freezes the measurement. The latest completed interval is presented both as a raw count and as a scaled code for a digital-to-analog converter. On that code, ten percent of the bit period is full scale.

Top module: `jitter_peak_tracker`

## Requirements
- R1: While reset is held and on the first sampled cycle after it, jitter_pct, last_count and dac_code are all 0.
- R2: A qualifying data transition is seen in the cycle in which data_in differs from its value one cycle earlier. Every later cycle with tick high adds one to the interval. The cycle with bit_edge high ends the interval without counting that cycle's tick, and last_count shows the result from the next cycle on.
- R3: The first interval completed after a start pulse (or after reset) becomes the stored minimum, and jitter_pct stays 0.
- R4: An interval below the stored minimum replaces it, and jitter_pct grows by the amount the minimum fell, so the tracked maximum is kept. Without a start pulse, jitter_pct never decreases.
- R5: An interval above minimum plus jitter_pct sets jitter_pct to that interval minus the minimum.
- R6: An interval between the minimum and minimum plus jitter_pct, inclusive, changes neither value.
- R7: With mode_total low (jitter mode), only rising transitions (0 to 1) start an interval. Falling transitions are ignored.
- R8: With mode_total high (total-peak mode), both rising and falling transitions start an interval.
- R9: A transition that arrives while an interval is being counted is ignored, and the running count goes on.
- R10: An interval whose count would reach LIMIT (100) before a bit-clock edge is discarded. last_count and jitter_pct keep their values, and a later bit_edge does not complete it.
- R11: While ext_sel is high, no interval is started or completed, and an interval in progress is dropped.
- R12: A start pulse clears jitter_pct to 0 in the next cycle and drops any interval in progress. The next completed interval is handled as in R3.
- R13: dac_code equals last_count × (2^DAC_W − 1) / FS_PCT, rounded down, and saturates at 2^DAC_W − 1 once last_count reaches FS_PCT (10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 1 | Received data, already synchronous to clk |
| bit_edge | input | 1 | One-cycle pulse marking a recovered bit-clock edge |
| tick | input | 1 | Sample tick at one hundred times the bit rate |
| mode_total | input | 1 | 0: rising transitions only; 1: both polarities |
| start | input | 1 | Clears the test and starts a new one |
| ext_sel | input | 1 | External clock selected; measurement frozen |
| jitter_pct | output | $clog2(LIMIT) | Peak-to-peak spread in percent of the bit period |
| last_count | output | $clog2(LIMIT) | Latest completed interval in percent |
| dac_code | output | DAC_W | Scaled latest interval for a converter |

## Verification
A wrong stored minimum stays hidden until the next completed interval. That interval is then judged against the wrong reference, and jitter_pct is off one cycle after last_count updates. A wrong running count appears on last_count in the cycle after the closing bit-clock edge. A missed discard or a wrongly accepted edge shows up as a new last_count value where the old one should have stayed. The reference model compares all three outputs every cycle, so each of these faults is reported within one cycle of the first output that differs.

// File: rtl/jpt_pkg.sv
// Package: shared types and helpers for the jitter peak tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package jpt_pkg;

    // Interval counter state: idle (waiting for a transition) or running.
    typedef enum logic {
        CTR_IDLE = 1'b0,
        CTR_RUN  = 1'b1
    } ctr_state_t;

    // Width needed to hold counts 0 .. limit-1.
    function automatic int unsigned count_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/jpt_edge_qual.sv
// Module: jpt_edge_qual
// Detects transitions on the sampled data line and keeps those that
// qualify for the selected mode: rising only, or both polarities.
// Assumes: data_in is already synchronous to clk.
module jpt_edge_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    input  logic mode_total,
    output logic qual
);

    logic data_q;
    logic rise;
    logic fall;

    // Hold last cycle's data level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 1'b0;
        end else begin
            data_q <= data_in;
        end
    end

    // Classify this cycle's transition and apply the mode filter.
    always_comb begin
        rise = data_in & ~data_q;
        fall = ~data_in & data_q;
        qual = rise | (mode_total & fall);
    end

endmodule

// File: rtl/jpt_interval_ctr.sv
// Module: jpt_interval_ctr
// Counts sample ticks from a qualifying transition to the next bit-clock
// edge. Ignores transitions while running. Discards an interval that would
// reach LIMIT. Emits a one-cycle done pulse with the finished count.
// Assumes: abort (start or external clock) takes precedence over all else.
module jpt_interval_ctr
    import jpt_pkg::*;
#(
    parameter int unsigned LIMIT = 100,
    parameter int unsigned CNT_W = count_width(LIMIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual,
    input  logic             bit_edge,
    input  logic             tick,
    input  logic             abort,
    output logic             done,
    output logic [CNT_W-1:0] interval,
    output logic             busy,
    output logic [CNT_W-1:0] count_cur
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    ctr_state_t       state;
    logic [CNT_W-1:0] cnt;

    // Run the idle/count sequence and latch the result on a bit-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CTR_IDLE;
            cnt      <= CNT_ZERO;
            done     <= 1'b0;
            interval <= CNT_ZERO;
        end else begin
            done <= 1'b0;
            if (abort) begin
                state <= CTR_IDLE;
            end else begin
                unique case (state)
                    CTR_IDLE: begin
                        if (qual) begin
                            state <= CTR_RUN;
                            cnt   <= CNT_ZERO;
                        end
                    end
                    CTR_RUN: begin
                        if (bit_edge) begin
                            state    <= CTR_IDLE;
                            done     <= 1'b1;
                            interval <= cnt;
                        end else if (tick) begin
                            if (cnt == CNT_LAST) begin
                                state <= CTR_IDLE;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    default: state <= CTR_IDLE;
                endcase
            end
        end
    end

    // Expose the running state for observation.
    always_comb begin
        busy      = (state == CTR_RUN);
        count_cur = cnt;
    end

endmodule

// File: rtl/jpt_peak_track.sv
// Module: jpt_peak_track
// Keeps a minimum store and a spread store (maximum minus minimum) over
// the completed intervals of one test. The maximum is implied by their sum.
// Assumes: done is a one-cycle pulse; start has priority over done.
module jpt_peak_track #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             done,
    input  logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] low_o,
    output logic [CNT_W-1:0] spread_o
);

    localparam int unsigned SUM_W = CNT_W + 1;

    logic             have_first;
    logic [CNT_W-1:0] low_q;
    logic [CNT_W-1:0] spread_q;
    logic [SUM_W-1:0] high_sum;
    logic             below_low;
    logic             above_high;

    // Form the implied maximum and compare the new interval against both bounds.
    always_comb begin
        high_sum   = {1'b0, low_q} + {1'b0, spread_q};
        below_low  = (interval < low_q);
        above_high = ({1'b0, interval} > high_sum);
    end

    // Update the minimum and spread stores on each completed interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_first <= 1'b0;
            low_q      <= '0;
            spread_q   <= '0;
        end else if (start) begin
            have_first <= 1'b0;
            low_q      <= '0;
            spread_q   <= '0;
        end else if (done) begin
            if (!have_first) begin
                have_first <= 1'b1;
                low_q      <= interval;
                spread_q   <= '0;
            end else if (below_low) begin
                low_q    <= interval;
                spread_q <= spread_q + (low_q - interval);
            end else if (above_high) begin
                spread_q <= interval - low_q;
            end
        end
    end

    // Drive the stored values out.
    always_comb begin
        low_o    = low_q;
        spread_o = spread_q;
    end

endmodule

// File: rtl/jpt_dac_scale.sv
// Module: jpt_dac_scale
// Maps an interval in percent onto a converter code in which FS_PCT
// percent is full scale. Saturates above that.
// Assumes: FS_PCT is nonzero.
module jpt_dac_scale #(
    parameter int unsigned CNT_W  = 7,
    parameter int unsigned DAC_W  = 8,
    parameter int unsigned FS_PCT = 10
) (
    input  logic [CNT_W-1:0] count_in,
    output logic [DAC_W-1:0] code
);

    localparam int unsigned    PROD_W   = CNT_W + DAC_W;
    localparam logic [DAC_W-1:0] CODE_MAX = {DAC_W{1'b1}};
    localparam logic [PROD_W-1:0] FS_EXT  = PROD_W'(FS_PCT);

    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] quotient;

    // Scale the count and clamp it at full scale.
    always_comb begin
        product  = PROD_W'(count_in) * PROD_W'(CODE_MAX);
        quotient = product / FS_EXT;
        if (PROD_W'(count_in) >= FS_EXT) begin
            code = CODE_MAX;
        end else begin
            code = quotient[DAC_W-1:0];
        end
    end

endmodule

// File: rtl/jitter_peak_tracker.sv
// Module: jitter_peak_tracker (top)
// Measures peak-to-peak edge-to-clock timing spread in percent of a bit
// period, using a sample tick at one hundred times the bit rate.
// Assumes: all inputs are synchronous to clk; bit_edge is a one-cycle pulse.
module jitter_peak_tracker
    import jpt_pkg::*;
#(
    parameter int unsigned LIMIT  = 100,
    parameter int unsigned FS_PCT = 10,
    parameter int unsigned DAC_W  = 8,
    parameter int unsigned CNT_W  = count_width(LIMIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_in,
    input  logic             bit_edge,
    input  logic             tick,
    input  logic             mode_total,
    input  logic             start,
    input  logic             ext_sel,
    output logic [CNT_W-1:0] jitter_pct,
    output logic [CNT_W-1:0] last_count,
    output logic [DAC_W-1:0] dac_code
);

    logic             edge_ok;
    logic             ctr_abort;
    logic             ctr_done;
    logic             ctr_busy;
    logic [CNT_W-1:0] ctr_count;
    logic [CNT_W-1:0] ctr_interval;
    logic [CNT_W-1:0] trk_low;
    logic [CNT_W-1:0] trk_spread;

    // A new test or an external clock stops any running interval.
    always_comb begin
        ctr_abort = start | ext_sel;
    end

    jpt_edge_qual u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_in    (data_in),
        .mode_total (mode_total),
        .qual       (edge_ok)
    );

    jpt_interval_ctr #(
        .LIMIT (LIMIT),
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .qual      (edge_ok),
        .bit_edge  (bit_edge),
        .tick      (tick),
        .abort     (ctr_abort),
        .done      (ctr_done),
        .interval  (ctr_interval),
        .busy      (ctr_busy),
        .count_cur (ctr_count)
    );

    jpt_peak_track #(
        .CNT_W (CNT_W)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .done     (ctr_done),
        .interval (ctr_interval),
        .low_o    (trk_low),
        .spread_o (trk_spread)
    );

    jpt_dac_scale #(
        .CNT_W  (CNT_W),
        .DAC_W  (DAC_W),
        .FS_PCT (FS_PCT)
    ) u_dac (
        .count_in (ctr_interval),
        .code     (dac_code)
    );

    // Drive the measurement outputs.
    always_comb begin
        jitter_pct = trk_spread;
        last_count = ctr_interval;
    end

endmodule

// File: rtl/jpt_checker.sv
// Module: jpt_checker
// Timing properties of the jitter peak tracker, bound to the top module.
// Assumes: connected to the top's internal counter and tracker signals.
module jpt_checker #(
    parameter int unsigned LIMIT = 100,
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ext_sel,
    input logic             ctr_done,
    input logic             ctr_busy,
    input logic [CNT_W-1:0] ctr_count,
    input logic [CNT_W-1:0] last_count,
    input logic [CNT_W-1:0] jitter_pct
);

    // R10: a running count never reaches the discard limit.
    assert_count_below_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_busy |-> (32'(ctr_count) < LIMIT));

    // R11: with the external clock selected, no interval completes next cycle.
    assert_ext_blocks_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |=> !ctr_done);

    // R12: a start pulse clears the spread and drops a running interval.
    assert_start_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (jitter_pct == '0) && !ctr_done);

    // R4: without a start pulse the spread never shrinks.
    assert_spread_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (jitter_pct >= $past(jitter_pct)));

    // R2: the reported interval only moves together with a completion pulse.
    assert_last_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctr_done |-> $stable(last_count));

endmodule

bind jitter_peak_tracker jpt_checker #(
    .LIMIT (LIMIT),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ext_sel    (ext_sel),
    .ctr_done   (ctr_done),
    .ctr_busy   (ctr_busy),
    .ctr_count  (ctr_count),
    .last_count (last_count),
    .jitter_pct (jitter_pct)
);

// File: tb/jitter_peak_tracker_tb.sv
// Bench: behavioural reference compared every cycle, plus directed checks.
module jitter_peak_tracker_tb;

    localparam int LIMIT  = 100;
    localparam int FS_PCT = 10;
    localparam int DAC_W  = 8;
    localparam int CNT_W  = 7;
    localparam int DMAX   = (1 << DAC_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             data_in = 1'b0;
    logic             bit_edge = 1'b0;
    logic             tick = 1'b0;
    logic             mode_total = 1'b0;
    logic             start = 1'b0;
    logic             ext_sel = 1'b0;
    logic [CNT_W-1:0] jitter_pct;
    logic [CNT_W-1:0] last_count;
    logic [DAC_W-1:0] dac_code;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    jitter_peak_tracker #(
        .LIMIT (LIMIT), .FS_PCT (FS_PCT), .DAC_W (DAC_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .data_in (data_in), .bit_edge (bit_edge),
        .tick (tick), .mode_total (mode_total), .start (start), .ext_sel (ext_sel),
        .jitter_pct (jitter_pct), .last_count (last_count), .dac_code (dac_code)
    );

    // Reference state, updated behaviourally at each rising edge.
    int  m_prev = 0, m_busy = 0, m_cnt = 0, m_last = 0, m_pend = 0;
    int  m_first = 1, m_low = 0, m_hi = 0;

    function automatic int exp_dac(input int c);
        return (c >= FS_PCT) ? DMAX : (c * DMAX) / FS_PCT;
    endfunction

    always @(posedge clk) begin
        int new_pend;
        bit q;
        if (!rst_n) begin
            m_prev = 0; m_busy = 0; m_cnt = 0; m_last = 0; m_pend = 0;
            m_first = 1; m_low = 0; m_hi = 0;
        end else begin
            if (start) begin
                m_first = 1; m_low = 0; m_hi = 0;
            end else if (m_pend != 0) begin
                if (m_first != 0) begin
                    m_first = 0; m_low = m_last; m_hi = m_last;
                end else begin
                    if (m_last < m_low) m_low = m_last;
                    if (m_last > m_hi) m_hi = m_last;
                end
            end
            q = (data_in && m_prev == 0) || (mode_total && !data_in && m_prev == 1);
            new_pend = 0;
            if (start || ext_sel) m_busy = 0;
            else if (m_busy == 0) begin
                if (q) begin m_busy = 1; m_cnt = 0; end
            end else if (bit_edge) begin
                m_busy = 0; m_last = m_cnt; new_pend = 1;
            end else if (tick) begin
                if (m_cnt + 1 == LIMIT) m_busy = 0;
                else m_cnt = m_cnt + 1;
            end
            m_prev = data_in ? 1 : 0;
            m_pend = new_pend;
        end
    end

    // Compare all outputs with the reference away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (int'(jitter_pct) != m_hi - m_low || int'(last_count) != m_last ||
                int'(dac_code) != exp_dac(m_last)) begin
                errors++;
                $display("FAIL model R2/R4/R13: jitter=%0d last=%0d dac=%0d expected %0d %0d %0d",
                         jitter_pct, last_count, dac_code, m_hi - m_low, m_last, exp_dac(m_last));
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Set a data level, then give n ticks and one bit-clock edge.
    task automatic measure(input bit lvl, input int n);
        data_in = lvl;
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
        bit_edge = 1'b1;
        @(negedge clk);
        bit_edge = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 jitter in reset", int'(jitter_pct), 0);
        chk("R1 last in reset", int'(last_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dac after reset", int'(dac_code), 0);
        pulse_start();

        measure(1'b1, 5);
        chk("R2 interval count", int'(last_count), 5);
        chk("R3 first interval spread", int'(jitter_pct), 0);
        chk("R13 scaled code", int'(dac_code), 127);
        measure(1'b0, 2);
        chk("R7 falling ignored", int'(last_count), 5);
        measure(1'b1, 8);
        chk("R5 new maximum", int'(jitter_pct), 3);
        measure(1'b0, 2);
        measure(1'b1, 3);
        chk("R4 new minimum keeps max", int'(jitter_pct), 5);
        chk("R13 small code", int'(dac_code), 76);
        measure(1'b0, 2);
        measure(1'b1, 6);
        chk("R6 inside range", int'(jitter_pct), 5);
        measure(1'b0, 2);
        measure(1'b1, 12);
        chk("R5 wider maximum", int'(jitter_pct), 9);
        chk("R13 saturation", int'(dac_code), DMAX);

        mode_total = 1'b1;
        measure(1'b0, 4);
        chk("R8 falling counts", int'(last_count), 4);

        // R9: a second transition mid-count does not restart the interval.
        data_in = 1'b1;
        @(negedge clk);
        tick = 1'b1;
        repeat (2) @(negedge clk);
        data_in = 1'b0;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        bit_edge = 1'b1;
        @(negedge clk);
        bit_edge = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 edge while counting", int'(last_count), 5);

        measure(1'b1, LIMIT);
        chk("R10 overflow discarded", int'(last_count), 5);
        chk("R10 spread kept", int'(jitter_pct), 9);

        ext_sel = 1'b1;
        measure(1'b0, 2);
        chk("R11 external clock freezes", int'(last_count), 5);
        ext_sel = 1'b0;
        @(negedge clk);

        pulse_start();
        chk("R12 start clears", int'(jitter_pct), 0);
        measure(1'b1, 7);
        chk("R12 first after start", int'(last_count), 7);
        chk("R3 spread after restart", int'(jitter_pct), 0);
        measure(1'b0, 9);
        chk("R5 spread after restart", int'(jitter_pct), 2);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule